// File: doc/BRIEF.md
# Ingress Packet Header Byte Reshuffler

The block sits between a processing-element port that delivers packets as a stream of 32-bit words and the input FIFO of a switch fabric. It holds one packet at a time in a register buffer. While the packet arrives, the block tracks its length, any bus parity errors and whether it is an idle packet. It also lifts a flow-control grant bit out of the packet's leading qualifier byte and reports it on a separate output.

Only a complete, accepted packet is released. Idle packets are dropped. Packets with a parity or length fault are also dropped, when the drop switch is set. On release, the first four words become a new header. In that header the qualifier byte is rewritten into the fabric's format and given fresh odd parity. Every header byte is then filled from any byte of the first four input words through a 4-bit selector per output byte. Words after the header leave unchanged.

Both data edges use valid/ready handshakes. `in_ready` stays high while no finished packet waits. It falls as soon as a packet is held for output and rises again the cycle after that packet's last word is taken. The output keeps `out_valid` and `out_data` steady while `out_ready` is low. The configuration pins are plain levels and must stay stable while a packet is being drained.

Top module: `pkt_hdr_reshuffle`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 0 whenever `out_valid` is 1. The cycle after the last output word is taken, `in_ready` is 1 and `out_valid` is 0.
- R2: `out_valid` rises in the cycle after the word carrying `in_eop` is accepted, never earlier. While `out_ready` is 0, `out_valid` and `out_data` hold.
- R3: The qualifier byte is bits 31:24 of the first word. Its type field is bits 7:4. A packet whose type field equals `cfg_idle_code` produces no output.
- R4: The cycle after a first word (`in_sop`) is accepted, `grant_valid` is 1 for one cycle and `grant_bit` equals qualifier bit 3. This happens for idle packets too.
- R5: The rewritten qualifier is {type[3:0], 0, q[2:1], p}, where p makes the count of ones in the 8 bits odd.
- R6: Output header byte k (k = 0..15, in word k/4, byte k%4, with byte 0 at bits 31:24) takes the source named by `cfg_sel[4k+3:4k]`. Code bits 3:2 pick the input word (0..3) and bits 1:0 pick the byte. Source byte 0 of word 0 is the rewritten qualifier.
- R7: Words 4 and up leave unchanged and in order. `out_sop` marks the first output word and `out_eop` the last. A packet of 16 to 20 words leaves with the same length.
- R8: When `cfg_drop_err` is 1, a packet with `in_perr` set on any word is dropped. When it is 0, the packet is forwarded.
- R9: A packet shorter than 16 or longer than 20 words is dropped when `cfg_drop_err` is 1. When it is 0, the packet is forwarded, with an over-long packet cut to its first 20 words.
- R10: A word with `in_sop` starts a new packet and discards any partly received one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_perr | input | 1 | Bus parity error on this word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | First output word |
| out_eop | output | 1 | Last output word |
| grant_valid | output | 1 | One-cycle strobe: grant bit updated |
| grant_bit | output | 1 | Send-grant bit from the last first word |
| cfg_idle_code | input | 4 | Type value that marks an idle packet |
| cfg_drop_err | input | 1 | Drop packets with parity or length faults |
| cfg_sel | input | 64 | Sixteen 4-bit source selectors, byte k at bits 4k+3:4k |

## Verification
The remap is swept with sixteen rotated selector sets, so that every output byte draws from every source code at least once. A scattered permutation and an all-zero broadcast set are added. Together these separate a wrong word/byte split, a swapped byte order and a qualifier that was not rewritten. Lengths 15 to 22 are run with the drop switch both on and off to separate dropping from truncation. Every type code is tried against one idle code, so that exactly one drops. Qualifier values with varied grant and low bits check the extraction and the parity. A half packet cut off by a new start shows that stale words are discarded. Output back-pressure follows an irregular ready pattern throughout.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  localparam int QUAL_W = 8;

  // Fabric qualifier: type kept, grant bit cleared, two low bits kept,
  // odd parity in bit 0.
  function automatic logic [QUAL_W-1:0] qual_rewrite(input logic [QUAL_W-1:0] q);
    logic [QUAL_W-2:0] body;
    body = {q[7:4], 1'b0, q[2:1]};
    return {body, ~(^body)};
  endfunction
endpackage

// File: rtl/rsh_capture.sv
module rsh_capture #(
  parameter int WORD_W    = 32,
  parameter int MIN_WORDS = 16,
  parameter int MAX_WORDS = 20,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORD_W-1:0]           in_data,
  input  logic                        in_sop,
  input  logic                        in_eop,
  input  logic                        in_perr,
  input  logic [3:0]                  cfg_idle_code,
  input  logic                        cfg_drop_err,
  input  logic                        release_done,
  output logic                        held,
  output logic [CNT_W-1:0]            pkt_len,
  output logic [MAX_WORDS*WORD_W-1:0] buf_flat,
  output logic                        grant_valid,
  output logic                        grant_bit
);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(MAX_WORDS);
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(MIN_WORDS);

  logic [WORD_W-1:0] mem [MAX_WORDS];
  logic [CNT_W-1:0]  cnt, base, nxt;
  logic              idle_q, perr_q, over_q;
  logic              acc, full_now, idle_w, perr_w, over_w, short_w, drop;

  assign in_ready = !held;
  assign acc      = in_valid && !held;
  assign base     = in_sop ? '0 : cnt;
  assign full_now = (base == LIM_HI);
  assign nxt      = full_now ? base : base + 1'b1;
  assign idle_w   = in_sop ? (in_data[WORD_W-1 -: 4] == cfg_idle_code) : idle_q;
  assign perr_w   = (in_sop ? 1'b0 : perr_q) | in_perr;
  assign over_w   = (in_sop ? 1'b0 : over_q) | full_now;
  assign short_w  = (nxt < LIM_LO);
  assign drop     = idle_w || (cfg_drop_err && (perr_w || over_w || short_w));

  always_ff @(posedge clk) begin
    if (acc && !full_now) mem[base] <= in_data;
  end

  generate
    for (genvar i = 0; i < MAX_WORDS; i++) begin : g_flat
      assign buf_flat[i*WORD_W +: WORD_W] = mem[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      idle_q      <= 1'b0;
      perr_q      <= 1'b0;
      over_q      <= 1'b0;
      held        <= 1'b0;
      pkt_len     <= '0;
      grant_valid <= 1'b0;
      grant_bit   <= 1'b0;
    end else begin
      grant_valid <= acc && in_sop;
      if (acc && in_sop) grant_bit <= in_data[WORD_W-5];
      if (release_done) held <= 1'b0;
      if (acc) begin
        if (in_eop) begin
          cnt    <= '0;
          idle_q <= 1'b0;
          perr_q <= 1'b0;
          over_q <= 1'b0;
          if (!drop) begin
            held    <= 1'b1;
            pkt_len <= nxt;
          end
        end else begin
          cnt    <= nxt;
          idle_q <= idle_w;
          perr_q <= perr_w;
          over_q <= over_w;
        end
      end
    end
  end

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) && $past(cfg_drop_err) |-> (pkt_len >= LIM_LO) && (pkt_len <= LIM_HI)); // R9
  AST_HOLD_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(in_valid && in_eop)); // R2
endmodule

// File: rtl/rsh_remap.sv
module rsh_remap #(
  parameter int WORD_W    = 32,
  parameter int HDR_WORDS = 4,
  parameter int BYTES     = WORD_W / 8,
  parameter int HDR_BYTES = HDR_WORDS * BYTES,
  parameter int SEL_W     = $clog2(HDR_BYTES)
) (
  input  logic [HDR_WORDS*WORD_W-1:0] hdr_in,
  input  logic [HDR_BYTES*SEL_W-1:0]  sel,
  output logic [HDR_WORDS*WORD_W-1:0] hdr_out
);
  logic [7:0] src [HDR_BYTES];

  generate
    for (genvar w = 0; w < HDR_WORDS; w++) begin : g_src_w
      for (genvar b = 0; b < BYTES; b++) begin : g_src_b
        if (w == 0 && b == 0) begin : g_qual
          assign src[0] = rsh_pkg::qual_rewrite(hdr_in[WORD_W-1 -: 8]);
        end else begin : g_plain
          assign src[w*BYTES+b] = hdr_in[w*WORD_W + WORD_W-1-8*b -: 8];
        end
      end
    end
    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_dst
      assign hdr_out[(k/BYTES)*WORD_W + WORD_W-1-8*(k%BYTES) -: 8] = src[sel[k*SEL_W +: SEL_W]];
    end
  endgenerate
endmodule

// File: rtl/rsh_drain.sv
module rsh_drain #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 20,
  parameter int HDR_WORDS = 4,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    held,
  input  logic [CNT_W-1:0]                        pkt_len,
  input  logic [HDR_WORDS*WORD_W-1:0]             hdr_flat,
  input  logic [(MAX_WORDS-HDR_WORDS)*WORD_W-1:0] tail_flat,
  input  logic                                    out_ready,
  output logic                                    out_valid,
  output logic [WORD_W-1:0]                       out_data,
  output logic                                    out_sop,
  output logic                                    out_eop,
  output logic                                    release_done
);
  logic [WORD_W-1:0] words [MAX_WORDS];
  logic [CNT_W-1:0]  rd;

  generate
    for (genvar i = 0; i < MAX_WORDS; i++) begin : g_w
      if (i < HDR_WORDS) begin : g_hdr
        assign words[i] = hdr_flat[i*WORD_W +: WORD_W];
      end else begin : g_tail
        assign words[i] = tail_flat[(i-HDR_WORDS)*WORD_W +: WORD_W];
      end
    end
  endgenerate

  assign out_valid    = held;
  assign out_data     = words[rd];
  assign out_sop      = (rd == '0);
  assign out_eop      = (rd == pkt_len - 1'b1);
  assign release_done = held && out_ready && out_eop;

  always_ff @(posedge clk) begin
    if (!rst_n)               rd <= '0;
    else if (release_done)    rd <= '0;
    else if (held && out_ready) rd <= rd + 1'b1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(rd)); // R2
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rd < pkt_len); // R7
endmodule

// File: rtl/pkt_hdr_reshuffle.sv
module pkt_hdr_reshuffle #(
  parameter int WORD_W    = 32,
  parameter int MIN_WORDS = 16,
  parameter int MAX_WORDS = 20,
  parameter int HDR_WORDS = 4,
  localparam int BYTES     = WORD_W / 8,
  localparam int HDR_BYTES = HDR_WORDS * BYTES,
  localparam int SEL_W     = $clog2(HDR_BYTES),
  localparam int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_W-1:0]          in_data,
  input  logic                       in_sop,
  input  logic                       in_eop,
  input  logic                       in_perr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WORD_W-1:0]          out_data,
  output logic                       out_sop,
  output logic                       out_eop,
  output logic                       grant_valid,
  output logic                       grant_bit,
  input  logic [3:0]                 cfg_idle_code,
  input  logic                       cfg_drop_err,
  input  logic [HDR_BYTES*SEL_W-1:0] cfg_sel
);
  logic                        held, release_done;
  logic [CNT_W-1:0]            pkt_len;
  logic [MAX_WORDS*WORD_W-1:0] buf_flat;
  logic [HDR_WORDS*WORD_W-1:0] hdr_flat;

  rsh_capture #(.WORD_W(WORD_W), .MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_cap (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_eop, .in_perr,
    .cfg_idle_code, .cfg_drop_err, .release_done, .held, .pkt_len, .buf_flat,
    .grant_valid, .grant_bit
  );

  rsh_remap #(.WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS)) u_map (
    .hdr_in (buf_flat[HDR_WORDS*WORD_W-1:0]),
    .sel    (cfg_sel),
    .hdr_out(hdr_flat)
  );

  rsh_drain #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .HDR_WORDS(HDR_WORDS), .CNT_W(CNT_W)) u_drn (
    .clk, .rst_n, .held, .pkt_len, .hdr_flat,
    .tail_flat(buf_flat[MAX_WORDS*WORD_W-1:HDR_WORDS*WORD_W]),
    .out_ready, .out_valid, .out_data, .out_sop, .out_eop, .release_done
  );

  AST_NO_DUAL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1
  AST_RESUME_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> in_ready && !out_valid); // R1
endmodule

// File: tb/pkt_hdr_reshuffle_test.sv
module pkt_hdr_reshuffle_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_perr = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_sop, out_eop, grant_valid, grant_bit;
  logic [31:0] out_data;
  logic [3:0]  cfg_idle_code = 4'hF;
  logic        cfg_drop_err = 1'b1;
  logic [63:0] cfg_sel = '0;

  int n_tests = 0, n_fail = 0, bp = 0;
  logic [31:0] pw [24];
  logic [31:0] ew [24];
  int elen;

  always #4 clk = ~clk;

  pkt_hdr_reshuffle uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_eop, .in_perr,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop, .grant_valid, .grant_bit,
    .cfg_idle_code, .cfg_drop_err, .cfg_sel
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed, input logic [7:0] qual, input int n);
    for (int i = 0; i < 24; i++)
      pw[i] = {8'(i*17 + seed), 8'(seed*3 + i), 8'(i ^ seed), 8'(255 - i)};
    pw[0][31:24] = qual;
    elen = (n > 20) ? 20 : n;
  endtask

  // Model of R5/R6/R7: rewritten qualifier, selector remap, tail copy.
  task automatic calc_exp();
    logic [7:0] src [16];
    logic [6:0] body;
    body = {pw[0][31:28], 1'b0, pw[0][26:25]};
    for (int k = 0; k < 16; k++) src[k] = pw[k/4][31-8*(k%4) -: 8];
    src[0] = {body, ~(^body)};
    for (int w = 0; w < 24; w++) ew[w] = pw[w];
    for (int k = 0; k < 16; k++) ew[k/4][31-8*(k%4) -: 8] = src[cfg_sel[4*k +: 4]];
  endtask

  task automatic send(input int n, input int perr_at, input bit with_eop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) chk(grant_valid && grant_bit == pw[0][27], "R4 grant", {grant_valid, grant_bit}, {1'b1, pw[0][27]});
      in_valid = 1'b1; in_data = pw[i]; in_sop = (i == 0);
      in_eop = with_eop && (i == n-1); in_perr = (i == perr_at);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_perr = 1'b0;
  endtask

  task automatic rx(input string req);
    int got = 0, guard = 0;
    bit done = 0;
    chk(out_valid && !in_ready, "R2 R1 held after eop", {out_valid, in_ready}, 2'b10);
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
      out_ready = (bp % 3) != 2;
      bp++;
      if (out_valid && out_ready) begin
        if (got < 24) chk(out_data == ew[got], req, out_data, ew[got]);
        chk(out_sop == (got == 0) && out_eop == (got == elen-1), "R7 markers", {out_sop, out_eop}, {got == 0, got == elen-1});
        if (out_eop) done = 1;
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == elen, "R7 length", got, elen);
    chk(in_ready && !out_valid, "R1 resume", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic expect_drop(input string req);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid && in_ready, req, {out_valid, in_ready}, 2'b01);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !grant_valid, "R1 reset", {in_ready, out_valid, grant_valid}, 3'b100);

    // R6: rotated selector sets, every code reaches every byte
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 16; k++) cfg_sel[4*k +: 4] = 4'((k + s) % 16);
      fill(s + 1, 8'(8'h25 + s*9), 16); calc_exp();
      send(16, -1, 1); rx("R6 rotate");
    end
    for (int k = 0; k < 16; k++) cfg_sel[4*k +: 4] = 4'((k*5 + 3) % 16);
    fill(40, 8'h3A, 17); calc_exp(); send(17, -1, 1); rx("R6 permute");
    cfg_sel = '0;
    fill(41, 8'hCE, 16); calc_exp(); send(16, -1, 1); rx("R6 R5 broadcast qualifier");

    // R7: legal lengths, tail unchanged
    for (int k = 0; k < 16; k++) cfg_sel[4*k +: 4] = 4'(k);
    for (int n = 16; n <= 20; n++) begin
      fill(50 + n, 8'(8'h10 + n), n); calc_exp(); send(n, -1, 1); rx("R7 length sweep");
    end

    // R3: only the idle type drops
    cfg_idle_code = 4'h5;
    for (int t = 0; t < 16; t++) begin
      fill(70 + t, {4'(t), 4'(t*3)}, 16); calc_exp(); send(16, -1, 1);
      if (t == 5) expect_drop("R3 idle dropped"); else rx("R3 non-idle forwarded");
    end
    cfg_idle_code = 4'hF;

    // R8: parity error
    fill(90, 8'h48, 18); calc_exp(); send(18, 9, 1); expect_drop("R8 perr dropped");
    cfg_drop_err = 1'b0;
    fill(91, 8'h49, 18); calc_exp(); send(18, 9, 1); rx("R8 perr forwarded");
    cfg_drop_err = 1'b1;

    // R9: length faults
    fill(92, 8'h4A, 15); send(15, -1, 1); expect_drop("R9 short dropped");
    fill(93, 8'h4B, 21); send(21, -1, 1); expect_drop("R9 long dropped");
    cfg_drop_err = 1'b0;
    fill(94, 8'h4C, 15); calc_exp(); send(15, -1, 1); rx("R9 short forwarded");
    fill(95, 8'h4D, 22); calc_exp(); send(22, -1, 1); rx("R9 long truncated");
    cfg_drop_err = 1'b1;

    // R10: new start discards partial packet
    fill(96, 8'h6E, 5); send(5, 2, 0);
    fill(97, 8'h6F, 16); calc_exp(); send(16, -1, 1); rx("R10 restart");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule